// File: doc/BRIEF.md
# Register Bitfield Extract and Insert Unit

This unit operates on one 32-bit data word per request. In extract mode it pulls a bitfield out of the source word and returns it right-justified, either zero-extended or sign-extended. In insert mode it writes the low bits of the source word into a bitfield of the destination word and leaves every other destination bit as it was. The field position and size come from a 16-bit control word. Each of the two can instead be taken from a register operand.

Bit offsets count from the most significant bit, so offset 0 names bit 31. A field whose offset plus width is more than 32 wraps past bit 0 and continues at bit 31. The unit also returns negative and zero flags that describe the field. The overflow and carry flags are always returned as zero.

Requests arrive on a valid/ready handshake. Each accepted request produces exactly one registered response, and the response stays held while the consumer stalls.

Top module: `bf_unit`

## Requirements
- R1: The width code is ctrl_i[4:0]. The effective width is ((code-1) mod 32)+1, so code 0 selects a 32-bit field.
- R2: The offset code is ctrl_i[10:6]. Offset 0 is bit 31, and larger offsets move toward bit 0.
- R3: When ctrl_i[5] is 1, the width code is taken from wid_reg_i[4:0]. The upper bits of wid_reg_i are ignored.
- R4: When ctrl_i[11] is 1, the offset is taken from ofs_reg_i reduced modulo 32.
- R5: A field with offset plus width greater than 32 wraps from bit 0 to bit 31. This applies to both extract and insert.
- R6: An extract with op_insert_i=0 and signed_i=0 returns the field zero-extended, with the field MSB at bit width-1.
- R7: An extract with signed_i=1 returns the field sign-extended to 32 bits.
- R8: For extract, N equals the field MSB in both the signed and unsigned forms. Z is 1 exactly when every field bit is 0.
- R9: Insert (op_insert_i=1) writes src_i[width-1:0] into the field of dst_i, with src_i[width-1] placed at the offset position. All other bits of dst_i pass through unchanged.
- R10: For insert, N is src_i[width-1]. Z is 1 exactly when src_i[width-1:0] is zero.
- R11: flag_v_o and flag_c_o are 0 after every operation.
- R12: req_ready_o equals !rsp_valid_o || rsp_ready_i. While rsp_valid_o=1 and rsp_ready_i=0, the result and flags hold steady. Each accepted request yields exactly one response, which is valid on the clock edge after acceptance.
- R13: Reset clears rsp_valid_o and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| op_insert_i | input | 1 | 1 selects insert, 0 selects extract |
| signed_i | input | 1 | Selects sign extension for extract |
| ctrl_i | input | 16 | Control word holding the width and offset codes and the register-select bits |
| src_i | input | 32 | Word to extract from, or the value to insert |
| dst_i | input | 32 | Destination word for insert |
| ofs_reg_i | input | 32 | Offset register operand |
| wid_reg_i | input | 32 | Width register operand |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Consumer accepts the response |
| result_o | output | 32 | Extracted field or updated destination word |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag, always 0 |
| flag_c_o | output | 1 | Carry flag, always 0 |

## Verification
The bench targets width code 0, where a design that treated the code literally would return an empty field or shift by 32. It also targets wrapping fields, where a design that shifted instead of rotating would lose the bits that continue at bit 31. Register operands are given large values so that a missing modulo-32 reduction would misplace the field. Signed extracts of negative fields and unsigned extracts with the MSB set both catch a design that takes N from the wrong form. A stalled consumer combined with a back-to-back request exposes a response that is overwritten or duplicated.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned BF_W  = 32;
  localparam int unsigned CTL_W = 16;
  // control word field positions
  localparam int unsigned WID_LSB = 0;
  localparam int unsigned WID_SEL = 5;
  localparam int unsigned OFS_LSB = 6;
  localparam int unsigned OFS_SEL = 11;

  typedef struct packed {
    logic n;
    logic z;
  } bf_flags_t;
endpackage

// File: rtl/bf_decode.sv
module bf_decode #(
  parameter int unsigned DW = bf_pkg::BF_W,
  parameter int unsigned CW = bf_pkg::CTL_W,
  localparam int unsigned AW = $clog2(DW)
) (
  input  logic [CW-1:0] ctrl_i,
  input  logic [DW-1:0] ofs_reg_i,
  input  logic [DW-1:0] wid_reg_i,
  output logic [AW-1:0] ofs_o,
  output logic [AW-1:0] sh_o
);
  logic [AW-1:0] wcode;
  logic          unused_bits;

  assign wcode = ctrl_i[bf_pkg::WID_SEL] ? wid_reg_i[AW-1:0]
                                          : ctrl_i[bf_pkg::WID_LSB +: AW];
  assign ofs_o = ctrl_i[bf_pkg::OFS_SEL] ? ofs_reg_i[AW-1:0]
                                          : ctrl_i[bf_pkg::OFS_LSB +: AW];
  // shift that left-justifies a field: DW - width, code 0 gives 0
  assign sh_o  = AW'(DW - 32'(wcode));

  assign unused_bits = ^{ctrl_i[CW-1:bf_pkg::OFS_SEL+1],
                         ofs_reg_i[DW-1:AW], wid_reg_i[DW-1:AW]};
endmodule

// File: rtl/bf_extract.sv
module bf_extract #(
  parameter int unsigned DW = bf_pkg::BF_W,
  localparam int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0]       word_i,
  input  logic [AW-1:0]       ofs_i,
  input  logic [AW-1:0]       sh_i,
  input  logic                sgn_i,
  output logic [DW-1:0]       field_o,
  output bf_pkg::bf_flags_t   flags_o
);
  logic [DW-1:0] rot, fu, fs;

  // rotate left so the field MSB lands on the top bit
  assign rot = (word_i << ofs_i) | (word_i >> (DW - 32'(ofs_i)));
  assign fu  = rot >> sh_i;
  assign fs  = DW'($signed(rot) >>> sh_i);

  assign field_o   = sgn_i ? fs : fu;
  assign flags_o.n = rot[DW-1];
  assign flags_o.z = (fu == '0);
endmodule

// File: rtl/bf_insert.sv
module bf_insert #(
  parameter int unsigned DW = bf_pkg::BF_W,
  localparam int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0]       src_i,
  input  logic [DW-1:0]       dst_i,
  input  logic [AW-1:0]       ofs_i,
  input  logic [AW-1:0]       sh_i,
  output logic [DW-1:0]       word_o,
  output bf_pkg::bf_flags_t   flags_o
);
  logic [DW-1:0] left, mtop, val_r, msk_r;

  assign left = src_i << sh_i;
  assign mtop = {DW{1'b1}} << sh_i;
  // rotate right by offset to move the left-justified field into place
  assign val_r = (left >> ofs_i) | (left << (DW - 32'(ofs_i)));
  assign msk_r = (mtop >> ofs_i) | (mtop << (DW - 32'(ofs_i)));

  assign word_o    = (dst_i & ~msk_r) | (val_r & msk_r);
  assign flags_o.n = left[DW-1];
  assign flags_o.z = (left == '0);
endmodule

// File: rtl/bf_unit.sv
module bf_unit #(
  parameter int unsigned DW = bf_pkg::BF_W,
  parameter int unsigned CW = bf_pkg::CTL_W,
  localparam int unsigned AW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          op_insert_i,
  input  logic          signed_i,
  input  logic [CW-1:0] ctrl_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] ofs_reg_i,
  input  logic [DW-1:0] wid_reg_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] result_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_v_o,
  output logic          flag_c_o
);
  import bf_pkg::*;

  logic [AW-1:0] ofs, sh;
  logic [DW-1:0] ext_val, ins_val;
  bf_flags_t     ext_fl, ins_fl, nxt_fl;
  logic          accept;

  bf_decode #(.DW(DW), .CW(CW)) u_dec (
    .ctrl_i(ctrl_i), .ofs_reg_i(ofs_reg_i), .wid_reg_i(wid_reg_i),
    .ofs_o(ofs), .sh_o(sh)
  );

  bf_extract #(.DW(DW)) u_ext (
    .word_i(src_i), .ofs_i(ofs), .sh_i(sh), .sgn_i(signed_i),
    .field_o(ext_val), .flags_o(ext_fl)
  );

  bf_insert #(.DW(DW)) u_ins (
    .src_i(src_i), .dst_i(dst_i), .ofs_i(ofs), .sh_i(sh),
    .word_o(ins_val), .flags_o(ins_fl)
  );

  assign nxt_fl      = op_insert_i ? ins_fl : ext_fl;
  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      result_o    <= '0;
      flag_n_o    <= 1'b0;
      flag_z_o    <= 1'b0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      result_o    <= op_insert_i ? ins_val : ext_val;
      flag_n_o    <= nxt_fl.n;
      flag_z_o    <= nxt_fl.z;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  assign flag_v_o = 1'b0;
  assign flag_c_o = 1'b0;
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk #(
  parameter int unsigned DW = bf_pkg::BF_W,
  parameter int unsigned CW = bf_pkg::CTL_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          op_insert_i,
  input logic          signed_i,
  input logic [CW-1:0] ctrl_i,
  input logic [DW-1:0] src_i,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [DW-1:0] result_o,
  input logic          flag_n_o,
  input logic          flag_z_o,
  input logic          flag_v_o,
  input logic          flag_c_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(result_o)
                                    && $stable(flag_n_o) && $stable(flag_z_o));

  assert_resp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  assert_vc_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !flag_v_o && !flag_c_o);

  assert_sext_n_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !op_insert_i && signed_i |=> flag_n_o == result_o[DW-1]);

  assert_ext_z_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !op_insert_i |=> flag_z_o == (result_o == '0));

  assert_full_insert_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_insert_i && ctrl_i[11:0] == 12'h000 |=> result_o == $past(src_i));
endmodule

bind bf_unit bf_unit_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/bf_unit_test.sv
module bf_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, op_insert_i = 1'b0, signed_i = 1'b0;
  logic        rsp_ready_i = 1'b1;
  logic [15:0] ctrl_i = '0;
  logic [31:0] src_i = '0, dst_i = '0, ofs_reg_i = '0, wid_reg_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] result_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  bf_unit uut (.*);

  always #4ns clk_i = ~clk_i;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bit-by-bit reference: field bit i (from MSB) lives at word bit 31-((ofs+i)%32)
  function automatic void model(input bit ins, input bit sgn, input logic [15:0] c,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] orr,
      input logic [31:0] wr, output logic [31:0] r, output bit n, output bit z);
    int ofs = c[11] ? int'(orr % 32) : int'(c[10:6]);
    int wc  = c[5] ? int'(wr[4:0]) : int'(c[4:0]);
    int w   = (wc == 0) ? 32 : wc;
    logic [31:0] f = '0;
    if (ins) begin
      r = d;
      for (int i = 0; i < w; i++) r[31 - ((ofs + i) % 32)] = s[w-1-i];
      n = s[w-1];
      z = 1;
      for (int i = 0; i < w; i++) if (s[i]) z = 0;
    end else begin
      for (int i = 0; i < w; i++) f[w-1-i] = s[31 - ((ofs + i) % 32)];
      n = f[w-1];
      z = (f == 0);
      if (sgn && n) for (int i = w; i < 32; i++) f[i] = 1'b1;
      r = f;
    end
  endfunction

  task automatic run_op(string tag, bit ins, bit sgn, logic [15:0] c, logic [31:0] s,
      logic [31:0] d, logic [31:0] orr, logic [31:0] wr);
    logic [31:0] er; bit en, ez;
    @(negedge clk_i);
    op_insert_i = ins; signed_i = sgn; ctrl_i = c; src_i = s; dst_i = d;
    ofs_reg_i = orr; wid_reg_i = wr; req_valid_i = 1; rsp_ready_i = 1;
    model(ins, sgn, c, s, d, orr, wr, er, en, ez);
    @(negedge clk_i);
    req_valid_i = 0;
    chk({tag, " R12 valid"}, 32'(rsp_valid_o), 32'd1);
    chk({tag, " result"}, result_o, er);
    chk({tag, " R8/R10 N"}, 32'(flag_n_o), 32'(en));
    chk({tag, " R8/R10 Z"}, 32'(flag_z_o), 32'(ez));
    chk({tag, " R11 VC"}, {30'd0, flag_v_o, flag_c_o}, 32'd0);
  endtask

  function automatic logic [15:0] mk(bit osel, int o, bit wsel, int w);
    return {4'd0, osel, 5'(o), wsel, 5'(w)};
  endfunction

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_0b1f));
    #20ns;
    chk("R13 reset valid", 32'(rsp_valid_o), 32'd0);
    chk("R13 reset flags", {28'd0, flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R12 ready idle", 32'(req_ready_o), 32'd1);

    run_op("R1 full-width extract",   0, 0, mk(0, 0, 0, 0),  32'hdead_beef, 0, 0, 0);
    run_op("R2 offset extract",       0, 0, mk(0, 4, 0, 8),  32'h0ab0_0000, 0, 0, 0);
    run_op("R5 wrap extract",         0, 0, mk(0, 28, 0, 8), 32'h8000_000f, 0, 0, 0);
    run_op("R7 signed negative",      0, 1, mk(0, 0, 0, 4),  32'hc000_0000, 0, 0, 0);
    run_op("R6 unsigned msb set",     0, 0, mk(0, 0, 0, 4),  32'hc000_0000, 0, 0, 0);
    run_op("R8 zero field",           0, 1, mk(0, 8, 0, 8),  32'hff00_ffff, 0, 0, 0);
    run_op("R3 reg width high bits",  0, 0, mk(0, 0, 1, 9),  32'hf000_0000, 0, 0, 32'hffff_ffe4);
    run_op("R3 reg width zero",       0, 1, mk(0, 0, 1, 0),  32'h1234_5678, 0, 0, 32'h0000_0020);
    run_op("R4 reg offset mod",       0, 0, mk(1, 0, 0, 4),  32'h0f00_0000, 0, 32'd36, 0);
    run_op("R9 insert middle",        1, 0, mk(0, 8, 0, 8),  32'h0000_00a5, 32'h1111_1111, 0, 0);
    run_op("R5 wrap insert",          1, 0, mk(0, 30, 0, 4), 32'h0000_0009, 32'h0000_0000, 0, 0);
    run_op("R1 full insert",          1, 0, mk(0, 0, 0, 0),  32'h8765_4321, 32'hffff_ffff, 0, 0);
    run_op("R10 insert zero src",     1, 0, mk(0, 0, 0, 4),  32'hffff_fff0, 32'hffff_ffff, 0, 0);

    for (int k = 0; k < 300; k++) begin
      bit ins = 1'($urandom);
      run_op(ins ? "R9 random insert" : "R6/R7 random extract", ins, 1'($urandom),
             16'($urandom), $urandom, $urandom, $urandom, $urandom);
    end

    // R12 backpressure: response held, second request stalled, then taken
    @(negedge clk_i);
    rsp_ready_i = 0; op_insert_i = 0; signed_i = 0; ctrl_i = mk(0, 0, 0, 8);
    src_i = 32'h5a00_0000; req_valid_i = 1;
    @(negedge clk_i);
    held = result_o;
    chk("R12 first response", result_o, 32'h0000_005a);
    src_i = 32'h3c00_0000;
    chk("R12 ready low when stalled", 32'(req_ready_o), 32'd0);
    @(negedge clk_i);
    chk("R12 held result", result_o, held);
    chk("R12 still valid", 32'(rsp_valid_o), 32'd1);
    rsp_ready_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R12 second response", result_o, 32'h0000_003c);
    @(negedge clk_i);
    chk("R12 single response", 32'(rsp_valid_o), 32'd0);

    finish_run();
  end
endmodule